// File: doc/BRIEF.md
# CPU Restart and A20 Gate Controller

This block collects every event that may restart the processor and every source that may move the A20 address gate. It produces a one-cycle CPU reset request, a one-cycle SMI request, and a registered final A20 level with an update strobe. A companion chip carries these over a control link. Everything runs on the 1x system clock.

The keyboard reset and A20 lines can come from three places: an external keyboard controller, whose asynchronous lines pass through synchronizers here; the internal keyboard controller; or fast emulation logic. Two configuration bits pick the source. A rising edge of the selected keyboard reset line is a restart request. So are a rising edge of the CPU shutdown indication, a 0-to-1 change of bit 0 of the fast system control register (when that trigger is enabled), and a write of 1 to the special reset bit. When two redirect bits are both set, every restart request becomes an SMI pulse instead of a CPU reset pulse. Firmware can then restart the processor in a safe way.

Top module: `cpu_restart_a20_ctl`

## Requirements
- R1: The selected keyboard source is chosen per signal as follows. With its emulate bit at 1, the emulation input is used whatever the enable bit says. With emulate 0, `cfg_int_kbc_en_i`=1 selects the internal controller and 0 selects the external one. `cfg_ga20_emu_i` governs the A20 line and `cfg_kbrst_emu_i` governs the keyboard reset line.
- R2: External controller lines pass through SYNC_STAGES (default 2) flops. A rising edge of the external keyboard reset line set up before edge k gives a request pulse after edge k+2. Internal and emulated lines are used without synchronization, so their effect shows after edge k.
- R3: A 0-to-1 change of `shutdown_i`, sampled at a clock edge, gives one request pulse visible after that edge. A level held high gives no further requests.
- R4: A write of the fast system control bit gives a request only when it changes the stored bit from 0 to 1 and `cfg_fsc_rst_en_i` is 1. The stored bit takes every written value whatever the enable says, and starts at 0.
- R5: A write strobe on `spc_wr_i` with `spc_wdata_i`=1 gives a request. A strobe with data 0 gives none.
- R6: When both `cfg_redir_en_i` and `cfg_redir_arm_i` are 1, a request pulses `smi_o` and leaves `cpu_rst_o` low. With either bit at 0, the request pulses `cpu_rst_o` and `smi_o` stays low. The two outputs are never high together.
- R7: Requests from several triggers in the same cycle give a single one-cycle pulse.
- R8: `ga20_o` takes the selected A20 source one edge after the source (post-synchronizer for external) differs from it. `ga20_upd_o` is high for exactly the cycles in which `ga20_o` has just changed. Unselected sources have no effect.
- R9: While `rst` is high at a clock edge, all outputs go to 0 (A20 masked), and all edge detectors, synchronizers and the stored fast control bit go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1x system clock |
| rst | input | 1 | Synchronous system reset, active high |
| shutdown_i | input | 1 | CPU shutdown cycle indication |
| ext_kbrst_i | input | 1 | External keyboard controller reset request (asynchronous, active high) |
| ext_ga20_i | input | 1 | External keyboard controller A20 level (asynchronous) |
| int_kbrst_i | input | 1 | Internal keyboard controller reset request |
| int_ga20_i | input | 1 | Internal keyboard controller A20 level |
| emu_kbrst_i | input | 1 | Fast emulation reset request |
| emu_ga20_i | input | 1 | Fast emulation A20 level |
| fsc_wr_i | input | 1 | Write strobe for the fast system control bit |
| fsc_wdata_i | input | 1 | Data for the fast system control bit |
| spc_wr_i | input | 1 | Write strobe for the special reset bit |
| spc_wdata_i | input | 1 | Data for the special reset bit |
| cfg_int_kbc_en_i | input | 1 | Internal keyboard controller enable |
| cfg_ga20_emu_i | input | 1 | Use emulation for A20 |
| cfg_kbrst_emu_i | input | 1 | Use emulation for keyboard reset |
| cfg_fsc_rst_en_i | input | 1 | Enable the fast control bit reset trigger |
| cfg_redir_en_i | input | 1 | Redirect enable, first of two bits |
| cfg_redir_arm_i | input | 1 | Redirect enable, second of two bits |
| cpu_rst_o | output | 1 | One-cycle CPU reset request |
| smi_o | output | 1 | One-cycle SMI request in place of a reset |
| ga20_o | output | 1 | Final A20 gate level |
| ga20_upd_o | output | 1 | Pulse when `ga20_o` changes |

## Verification
All eight settings of the enable and two emulate bits are tried. Under each one, every source's A20 and reset lines toggle in turn, so a wrong multiplexer leg shows as an output that moves when an unselected source toggles. External toggles catch a wrong synchronizer depth through the two-cycle extra lag. Each trigger is fired with redirection off, half-armed and fully armed, which separates the reset and SMI paths. Held levels, repeated fast-bit writes, data-0 special writes and two triggers in one cycle separate edge detection from level sensing and show that coincident requests merge into one pulse.

// File: rtl/cpu_restart_a20_ctl.sv
module cpu_restart_a20_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic shutdown_i,
  input  logic ext_kbrst_i,
  input  logic ext_ga20_i,
  input  logic int_kbrst_i,
  input  logic int_ga20_i,
  input  logic emu_kbrst_i,
  input  logic emu_ga20_i,
  input  logic fsc_wr_i,
  input  logic fsc_wdata_i,
  input  logic spc_wr_i,
  input  logic spc_wdata_i,
  input  logic cfg_int_kbc_en_i,
  input  logic cfg_ga20_emu_i,
  input  logic cfg_kbrst_emu_i,
  input  logic cfg_fsc_rst_en_i,
  input  logic cfg_redir_en_i,
  input  logic cfg_redir_arm_i,
  output logic cpu_rst_o,
  output logic smi_o,
  output logic ga20_o,
  output logic ga20_upd_o
);

  logic [SYNC_STAGES-1:0] kb_sync, ga_sync;
  logic shut_q, kb_q, fsc_q;
  logic kb_sel, ga_sel;

  always_comb begin
    if (cfg_kbrst_emu_i)       kb_sel = emu_kbrst_i;
    else if (cfg_int_kbc_en_i) kb_sel = int_kbrst_i;
    else                       kb_sel = kb_sync[SYNC_STAGES-1];
    if (cfg_ga20_emu_i)        ga_sel = emu_ga20_i;
    else if (cfg_int_kbc_en_i) ga_sel = int_ga20_i;
    else                       ga_sel = ga_sync[SYNC_STAGES-1];
  end

  wire redir    = cfg_redir_en_i & cfg_redir_arm_i;
  wire req_shut = shutdown_i & ~shut_q;
  wire req_kb   = kb_sel & ~kb_q;
  wire req_fsc  = fsc_wr_i & fsc_wdata_i & ~fsc_q & cfg_fsc_rst_en_i;
  wire req_spc  = spc_wr_i & spc_wdata_i;
  wire req_any  = req_shut | req_kb | req_fsc | req_spc;

  always_ff @(posedge clk) begin
    if (rst) begin
      kb_sync    <= '0;
      ga_sync    <= '0;
      shut_q     <= 1'b0;
      kb_q       <= 1'b0;
      fsc_q      <= 1'b0;
      cpu_rst_o  <= 1'b0;
      smi_o      <= 1'b0;
      ga20_o     <= 1'b0;
      ga20_upd_o <= 1'b0;
    end else begin
      kb_sync    <= {kb_sync[SYNC_STAGES-2:0], ext_kbrst_i};
      ga_sync    <= {ga_sync[SYNC_STAGES-2:0], ext_ga20_i};
      shut_q     <= shutdown_i;
      kb_q       <= kb_sel;
      if (fsc_wr_i) fsc_q <= fsc_wdata_i;
      cpu_rst_o  <= req_any & ~redir;
      smi_o      <= req_any & redir;
      ga20_o     <= ga_sel;
      ga20_upd_o <= ga_sel ^ ga20_o;
    end
  end

  assert_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(cpu_rst_o && smi_o));

  assert_redir_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_redir_en_i && cfg_redir_arm_i) |=> !cpu_rst_o);

  assert_spc_R5: assert property (@(posedge clk) disable iff (rst)
    (spc_wr_i && spc_wdata_i) |=> (cpu_rst_o || smi_o));

  assert_shut_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(shutdown_i) |=> (cpu_rst_o || smi_o));

  assert_upd_R8: assert property (@(posedge clk) disable iff (rst)
    ga20_upd_o |-> (ga20_o != $past(ga20_o)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ga20_upd_o |-> $stable(ga20_o));

endmodule

// File: tb/cpu_restart_a20_ctl_tb_top.sv
module cpu_restart_a20_ctl_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic shutdown_i = 0, ext_kbrst_i = 0, ext_ga20_i = 0, int_kbrst_i = 0, int_ga20_i = 0;
  logic emu_kbrst_i = 0, emu_ga20_i = 0, fsc_wr_i = 0, fsc_wdata_i = 0, spc_wr_i = 0, spc_wdata_i = 0;
  logic cfg_int_kbc_en_i = 0, cfg_ga20_emu_i = 0, cfg_kbrst_emu_i = 0, cfg_fsc_rst_en_i = 0;
  logic cfg_redir_en_i = 0, cfg_redir_arm_i = 0;
  logic cpu_rst_o, smi_o, ga20_o, ga20_upd_o;

  cpu_restart_a20_ctl dut_i (.*);

  int checks = 0, failures = 0, cycles = 0;
  string phase = "R9";

  // behavioural reference model
  bit ext_kb_q[$] = '{0, 0};
  bit ext_ga_q[$] = '{0, 0};
  bit m_shut = 0, m_kb = 0, m_fsc = 0;
  bit e_rst = 0, e_smi = 0, e_ga = 0, e_upd = 0;
  int n_rst = 0, n_smi = 0;

  always @(posedge clk) begin
    if (rst) begin
      ext_kb_q = '{0, 0}; ext_ga_q = '{0, 0};
      m_shut = 0; m_kb = 0; m_fsc = 0;
      e_rst = 0; e_smi = 0; e_ga = 0; e_upd = 0;
    end else begin
      bit skb, sga, req, rd;
      skb = cfg_kbrst_emu_i ? emu_kbrst_i : (cfg_int_kbc_en_i ? int_kbrst_i : ext_kb_q[0]);
      sga = cfg_ga20_emu_i ? emu_ga20_i : (cfg_int_kbc_en_i ? int_ga20_i : ext_ga_q[0]);
      req = 0;
      if (shutdown_i && !m_shut) req = 1;
      if (skb && !m_kb) req = 1;
      if (fsc_wr_i && fsc_wdata_i && !m_fsc && cfg_fsc_rst_en_i) req = 1;
      if (spc_wr_i && spc_wdata_i) req = 1;
      rd = cfg_redir_en_i && cfg_redir_arm_i;
      e_rst = req && !rd;
      e_smi = req && rd;
      e_upd = (sga != e_ga);
      e_ga = sga;
      m_shut = shutdown_i; m_kb = skb;
      if (fsc_wr_i) m_fsc = fsc_wdata_i;
      void'(ext_kb_q.pop_front()); ext_kb_q.push_back(ext_kbrst_i);
      void'(ext_ga_q.pop_front()); ext_ga_q.push_back(ext_ga20_i);
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cpu_rst_o) n_rst++;
    if (smi_o) n_smi++;
    chk(phase, "cpu_rst_o", cpu_rst_o, e_rst);
    chk(phase, "smi_o", smi_o, e_smi);
    chk(phase, "ga20_o", ga20_o, e_ga);
    chk(phase, "ga20_upd_o", ga20_upd_o, e_upd);
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_line(ref logic sig);
    @(negedge clk); sig = 1; wait_cyc(4); sig = 0; wait_cyc(4);
  endtask

  task automatic fsc_write(bit d);
    @(negedge clk); fsc_wr_i = 1; fsc_wdata_i = d;
    @(negedge clk); fsc_wr_i = 0; fsc_wdata_i = 0; wait_cyc(2);
  endtask

  task automatic spc_write(bit d);
    @(negedge clk); spc_wr_i = 1; spc_wdata_i = d;
    @(negedge clk); spc_wr_i = 0; spc_wdata_i = 0; wait_cyc(2);
  endtask

  task automatic fire_all_triggers();
    pulse_line(shutdown_i);
    fsc_write(0); fsc_write(1);
    spc_write(1);
    pulse_line(int_kbrst_i);
  endtask

  initial begin
    wait_cyc(3);
    chk("R9", "cpu_rst_o in reset", cpu_rst_o, 0);
    chk("R9", "ga20_o in reset", ga20_o, 0);
    @(negedge clk); rst = 0; wait_cyc(2);

    // R1, R8, R2: every source combination, toggle every source
    for (int c = 0; c < 8; c++) begin
      phase = (c == 0) ? "R2" : ((c % 2) ? "R8" : "R1");
      @(negedge clk);
      cfg_int_kbc_en_i = c[0]; cfg_ga20_emu_i = c[1]; cfg_kbrst_emu_i = c[2];
      wait_cyc(3);
      pulse_line(ext_ga20_i); pulse_line(int_ga20_i); pulse_line(emu_ga20_i);
      pulse_line(ext_kbrst_i); pulse_line(int_kbrst_i); pulse_line(emu_kbrst_i);
    end

    // R2: external reset edge lands after the third edge
    phase = "R2";
    @(negedge clk); cfg_int_kbc_en_i = 0; cfg_ga20_emu_i = 0; cfg_kbrst_emu_i = 0; wait_cyc(3);
    n_rst = 0;
    @(negedge clk); ext_kbrst_i = 1;
    wait_cyc(2); chk("R2", "no pulse before third edge", n_rst, 0);
    wait_cyc(1); chk("R2", "pulse after third edge", cpu_rst_o, 1);
    ext_kbrst_i = 0; wait_cyc(4);

    // R3: held shutdown gives one pulse
    phase = "R3"; n_rst = 0;
    @(negedge clk); shutdown_i = 1; wait_cyc(10); shutdown_i = 0; wait_cyc(3);
    chk("R3", "pulses for held shutdown", n_rst, 1);

    // R4: fast control bit trigger
    phase = "R4"; n_rst = 0;
    cfg_fsc_rst_en_i = 0; fsc_write(1); fsc_write(0);
    chk("R4", "pulses with trigger disabled", n_rst, 0);
    cfg_fsc_rst_en_i = 1; fsc_write(1); fsc_write(1);
    chk("R4", "pulses for 0->1 then 1->1", n_rst, 1);
    cfg_fsc_rst_en_i = 0; fsc_write(0); fsc_write(1); cfg_fsc_rst_en_i = 1; fsc_write(1);
    chk("R4", "stored bit tracks disabled writes", n_rst, 1);
    fsc_write(0);

    // R5: special reset bit
    phase = "R5"; n_rst = 0;
    spc_write(0); chk("R5", "data 0 pulses", n_rst, 0);
    spc_write(1); chk("R5", "data 1 pulses", n_rst, 1);

    // R6: redirect with each arming combination
    for (int r = 0; r < 4; r++) begin
      phase = "R6"; n_rst = 0; n_smi = 0;
      @(negedge clk); cfg_redir_en_i = r[0]; cfg_redir_arm_i = r[1]; cfg_int_kbc_en_i = 1;
      fire_all_triggers();
      chk("R6", "cpu_rst pulses", n_rst, (r == 3) ? 0 : 4);
      chk("R6", "smi pulses", n_smi, (r == 3) ? 4 : 0);
    end

    // R7: coincident requests merge
    phase = "R7"; n_rst = 0; n_smi = 0;
    @(negedge clk); cfg_redir_en_i = 0; cfg_redir_arm_i = 0;
    @(negedge clk); shutdown_i = 1; spc_wr_i = 1; spc_wdata_i = 1; int_kbrst_i = 1;
    @(negedge clk); spc_wr_i = 0; spc_wdata_i = 0;
    wait_cyc(3); shutdown_i = 0; int_kbrst_i = 0; wait_cyc(2);
    chk("R7", "merged pulses", n_rst, 1);

    // R9: reset mid-run clears A20
    phase = "R9";
    @(negedge clk); cfg_ga20_emu_i = 1; emu_ga20_i = 1; wait_cyc(2);
    chk("R9", "ga20 before reset", ga20_o, 1);
    rst = 1; wait_cyc(2);
    chk("R9", "ga20 after reset", ga20_o, 0);
    rst = 0; emu_ga20_i = 0; wait_cyc(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule